// File: doc/BRIEF.md
# Condition Register Mask-Match Predication Unit

This block executes a small family of predication instructions that test condition-register bits, or the lowest bit of an integer operand, against a per-bit polarity. The unit keeps an eight-field, 32-bit condition register. It accepts one 32-bit instruction word and one 64-bit operand on a cycle where `valid_i` is high. It retires the instruction on the next rising clock edge.

A 4-bit mask and a 4-bit mode from the instruction word produce a 4-bit match vector `n`. Each bit `n[i]` is high only when the mask bit is set and the mode bit equals the tested bit. Two selector bits pick one of four forms:
- **CR-to-integer**: the vector becomes an integer result, and CR field 0 is optionally updated from it.
- **Integer-to-CR**: the vector compares against the operand's least significant bit and is written to a CR field.
- **CR-to-CR**: the vector is written to another CR field.
- **CR-to-bit**: the vector is reduced by OR or AND into one CR bit.

A pipeline places it as one execution port. Register reads and writes for the integer file stay outside the block: the block only sees the operand value and reports the destination index with a write strobe. The block has no state machine. Its only state is the condition register and the registered result outputs.

Top module: `crpred_unit`

## Requirements
- R1: A synchronous reset on `rst_i` clears `cr_o` to zero and drives `int_we_o` and `illegal_o` low.
- R2: Bit b of the instruction word in MSB0 numbering is `insn_i[31-b]`. An instruction is accepted when all three of these hold: bits 0-5 equal 19, bits 21-25 equal parameter `EXT_OP` (default 0), and bit 26 is 0. Any other word presented with `valid_i` changes no state, leaves `int_we_o` low and raises `illegal_o` for exactly the following cycle.
- R3: The 4-bit mask is in bits 12-15 and the 4-bit mode is in bits 27-30. The match vector is `n[i] = mask[i] & (mode[i] == t[i])` for i = 0..3, where index 0 is the MSB0-first bit and `t` is the tested 4-bit value.
- R4: Selector bits 19,20 = 1,0 (CR-to-CR): `t` is CR field `S` (bits 16-18). CR field `D` (bits 6-8) is written with n0..n3 in MSB0 order.
- R5: Selector 0,1 (integer-to-CR): every `t[i]` is `opnd_i[0]`, the operand's least significant bit. When bits 6-10 are zero, the operand is treated as zero. CR field `S` (bits 16-18) is written with n0..n3.
- R6: Selector 1,1 (CR-to-bit): `t` is CR field `S`. Bits 6-10 form a target T. Bits 8-10 of T choose the field and bits 6-7 of T choose the bit within that field. That single bit receives OR(n) when M (bit 11) is 1, or AND(n) when M is 0. No other CR bit changes.
- R7: Selector 0,0 (CR-to-integer): `t` is CR field `S`. One cycle later `int_we_o` is high for one cycle, `int_rt_o` equals bits 6-10, and `int_res_o` equals n zero-extended with n0 at bit 3 and n3 at bit 0.
- R8: In CR-to-integer with Rc (bit 31) set, CR field 0 becomes {0, result != 0, result == 0, 0}. With Rc clear, the condition register is unchanged.
- R9: CR field k is held in `cr_o[31-4k : 28-4k]`, with its MSB0-first bit at the higher index.
- R10: With `valid_i` low, the condition register does not change and `int_we_o` and `illegal_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction and operand are presented this cycle |
| insn_i | input | 32 | Instruction word |
| opnd_i | input | 64 | Integer source operand |
| cr_o | output | 32 | Current condition register |
| int_we_o | output | 1 | Integer result write strobe |
| int_rt_o | output | 5 | Integer destination index |
| int_res_o | output | 64 | Integer result |
| illegal_o | output | 1 | Rejected instruction, one-cycle pulse |

## Verification
The bound checker watches four things on every cycle:
- A rejected word never disturbs the condition register.
- The write strobe and the illegal pulse never coincide.
- Integer results never carry bits above the match vector.
- Idle cycles and single-bit writes touch at most the bits they may.

The actual values need directed scenarios with a reference model in the bench. These cover the match formula under different polarities, the field and bit addressing, the OR and AND reductions, the forced-zero operand, and the CR field 0 flags.

// File: rtl/crpred_pkg.sv
package crpred_pkg;
    localparam int NFLD  = 8;
    localparam int FW    = 4;
    localparam int CRW   = NFLD * FW;
    localparam int XLEN  = 64;
    localparam int FSELW = $clog2(NFLD);

    typedef enum logic [2:0] {
        OP_CR2INT,
        OP_INT2CR,
        OP_CR2CR,
        OP_CR2BIT,
        OP_NONE
    } op_e;

    // field order follows MSB0 bit order of the word
    typedef struct packed {
        logic [5:0] opcd;
        logic [4:0] tgt;
        logic       m;
        logic [3:0] mask;
        logic [2:0] src;
        logic [1:0] sel;
        logic [4:0] xo;
        logic       b26;
        logic [3:0] mode;
        logic       rc;
    } insn_t;
endpackage

// File: rtl/crpred_decode.sv
module crpred_decode
    import crpred_pkg::*;
#(
    parameter logic [5:0] PRI_OP = 6'd19,
    parameter logic [4:0] EXT_OP = 5'd0
) (
    input  insn_t ins,
    output op_e   op,
    output logic  legal
);
    always_comb begin
        legal = (ins.opcd == PRI_OP) && (ins.xo == EXT_OP) && !ins.b26;
        op    = OP_NONE;
        if (legal) begin
            unique case (ins.sel)
                2'b00: op = OP_CR2INT;
                2'b01: op = OP_INT2CR;
                2'b10: op = OP_CR2CR;
                2'b11: op = OP_CR2BIT;
            endcase
        end
    end
endmodule

// File: rtl/crpred_match.sv
module crpred_match #(
    parameter int W = 4
) (
    input  logic [W-1:0] mask,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] tst,
    output logic [W-1:0] n,
    output logic         any_n,
    output logic         all_n
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign n[i] = mask[i] & (mode[i] == tst[i]);
        end
    endgenerate
    assign any_n = |n;
    assign all_n = &n;
endmodule

// File: rtl/crpred_crfile.sv
module crpred_crfile #(
    parameter int NFLD = 8,
    parameter int FW   = 4,
    localparam int CRW  = NFLD * FW,
    localparam int FSW  = $clog2(NFLD),
    localparam int BSW  = $clog2(FW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fld_we,
    input  logic [FSW-1:0] fld_idx,
    input  logic [FW-1:0]  fld_data,
    input  logic           bit_we,
    input  logic [FSW-1:0] bit_fld,
    input  logic [BSW-1:0] bit_pos,
    input  logic           bit_data,
    output logic [CRW-1:0] cr
);
    logic [CRW-1:0] cr_q;
    logic [CRW-1:0] cr_d;

    genvar f, j;
    generate
        for (f = 0; f < NFLD; f++) begin : g_fld
            for (j = 0; j < FW; j++) begin : g_bit
                localparam int P = CRW - 1 - FW * f - j;
                assign cr_d[P] =
                    (fld_we && fld_idx == FSW'(f)) ? fld_data[FW-1-j] :
                    (bit_we && bit_fld == FSW'(f) && bit_pos == BSW'(j)) ? bit_data :
                    cr_q[P];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) cr_q <= '0;
        else     cr_q <= cr_d;
    end

    assign cr = cr_q;
endmodule

// File: rtl/crpred_unit.sv
module crpred_unit
    import crpred_pkg::*;
#(
    parameter logic [5:0] PRI_OP = 6'd19,
    parameter logic [4:0] EXT_OP = 5'd0
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            valid_i,
    input  logic [31:0]     insn_i,
    input  logic [XLEN-1:0] opnd_i,
    output logic [CRW-1:0]  cr_o,
    output logic            int_we_o,
    output logic [4:0]      int_rt_o,
    output logic [XLEN-1:0] int_res_o,
    output logic            illegal_o
);
    insn_t ins;
    op_e   op;
    logic  legal;
    assign ins = insn_t'(insn_i);

    crpred_decode #(.PRI_OP(PRI_OP), .EXT_OP(EXT_OP)) u_dec (
        .ins(ins), .op(op), .legal(legal)
    );

    logic [CRW-1:0] cr;
    logic [FW-1:0]  src_bits, tst, n;
    logic           any_n, all_n, int_lsb;
    logic           unused_opnd;

    assign unused_opnd = ^opnd_i[XLEN-1:1];
    assign src_bits    = cr[CRW-1-FW*int'(ins.src) -: FW];
    assign int_lsb     = (ins.tgt == 5'd0) ? 1'b0 : opnd_i[0];
    assign tst         = (op == OP_INT2CR) ? {FW{int_lsb}} : src_bits;

    crpred_match #(.W(FW)) u_match (
        .mask(ins.mask), .mode(ins.mode), .tst(tst),
        .n(n), .any_n(any_n), .all_n(all_n)
    );

    logic             fire, fld_we, bit_we;
    logic [FSELW-1:0] fld_idx;
    logic [FW-1:0]    fld_data;

    assign fire = valid_i && legal;

    always_comb begin
        fld_we   = 1'b0;
        bit_we   = 1'b0;
        fld_idx  = '0;
        fld_data = n;
        unique case (op)
            OP_CR2INT: begin
                fld_we   = fire && ins.rc;
                fld_data = {1'b0, any_n, !any_n, 1'b0};
            end
            OP_INT2CR: begin
                fld_we  = fire;
                fld_idx = ins.src;
            end
            OP_CR2CR: begin
                fld_we  = fire;
                fld_idx = ins.tgt[4:2];
            end
            OP_CR2BIT: bit_we = fire;
            OP_NONE:   ;
            default:   ;
        endcase
    end

    crpred_crfile #(.NFLD(NFLD), .FW(FW)) u_cr (
        .clk(clk_i), .rst(rst_i),
        .fld_we(fld_we), .fld_idx(fld_idx), .fld_data(fld_data),
        .bit_we(bit_we), .bit_fld(ins.tgt[2:0]), .bit_pos(ins.tgt[4:3]),
        .bit_data(ins.m ? any_n : all_n),
        .cr(cr)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            int_we_o  <= 1'b0;
            int_rt_o  <= '0;
            int_res_o <= '0;
            illegal_o <= 1'b0;
        end else begin
            int_we_o  <= fire && (op == OP_CR2INT);
            int_rt_o  <= ins.tgt;
            int_res_o <= {{(XLEN-FW){1'b0}}, n};
            illegal_o <= valid_i && !legal;
        end
    end

    assign cr_o = cr;
endmodule

// File: rtl/crpred_unit_chk.sv
module crpred_unit_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        valid_i,
    input logic [31:0] insn_i,
    input logic [31:0] cr_o,
    input logic        int_we_o,
    input logic [63:0] int_res_o,
    input logic        illegal_o
);
    // R2
    illegal_keeps_cr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> $stable(cr_o));

    // R2
    illegal_no_we_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(illegal_o && int_we_o));

    // R7
    res_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        int_we_o |-> (int_res_o[63:4] == 60'd0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(valid_i) |-> ($stable(cr_o) && !int_we_o && !illegal_o));

    // R6
    single_bit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(valid_i) && $past(insn_i[31:26]) == 6'd19 && $past(insn_i[12:11]) == 2'b11)
        |-> ($countones(cr_o ^ $past(cr_o)) <= 1));
endmodule

bind crpred_unit crpred_unit_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .valid_i(valid_i), .insn_i(insn_i),
    .cr_o(cr_o), .int_we_o(int_we_o), .int_res_o(int_res_o), .illegal_o(illegal_o)
);

// File: tb/crpred_unit_bench.sv
module crpred_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid;
    logic [31:0] insn;
    logic [63:0] opnd;
    logic [31:0] cr;
    logic        int_we;
    logic [4:0]  int_rt;
    logic [63:0] int_res;
    logic        illegal;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_cr;

    always #10 clk = ~clk;

    crpred_unit u_crpred_unit (
        .clk_i(clk), .rst_i(rst), .valid_i(valid), .insn_i(insn), .opnd_i(opnd),
        .cr_o(cr), .int_we_o(int_we), .int_rt_o(int_rt), .int_res_o(int_res),
        .illegal_o(illegal)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] tgt,
        input logic m, input logic [3:0] mask, input logic [2:0] src,
        input logic [1:0] sel, input logic [4:0] xo, input logic b26,
        input logic [3:0] mode, input logic rc);
        return {opc, tgt, m, mask, src, sel, xo, b26, mode, rc};
    endfunction

    function automatic logic [31:0] put_fld(input logic [31:0] c, input int f,
                                            input logic [3:0] v);
        logic [31:0] r = c;
        r[31-4*f -: 4] = v;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] w, input logic [63:0] d);
        @(negedge clk);
        insn  = w;
        opnd  = d;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(cr == 32'd0, "R1 cr", 64'(cr), 64'd0);
        chk(!int_we && !illegal, "R1 strobes", {62'd0, int_we, illegal}, 64'd0);
    endtask

    task automatic t_int2cr;
        // R5: RA=5, lsb 1, mode 1100 mask 1111 -> n=1100 into field 2
        run(mk(6'd19, 5'd5, 1'b0, 4'hF, 3'd2, 2'b01, 5'd0, 1'b0, 4'b1100, 1'b0), 64'h3);
        exp_cr = put_fld(exp_cr, 2, 4'b1100);
        chk(cr == exp_cr, "R5 lsb one", 64'(cr), 64'(exp_cr));
        // R5: RA=0 forces operand zero, mode 0000 -> 1111 into field 5 (R9 layout)
        run(mk(6'd19, 5'd0, 1'b0, 4'hF, 3'd5, 2'b01, 5'd0, 1'b0, 4'b0000, 1'b0), 64'hF);
        exp_cr = put_fld(exp_cr, 5, 4'b1111);
        chk(cr == exp_cr, "R5 ra zero", 64'(cr), 64'(exp_cr));
        chk(cr[11:8] == 4'b1111, "R9 field5 position", 64'(cr[11:8]), 64'hF);
    endtask

    task automatic t_setclr;
        // R3: mode all ones, mask 0101 -> field 5 = 0000
        run(mk(6'd19, 5'd0, 1'b0, 4'b0101, 3'd5, 2'b01, 5'd0, 1'b0, 4'b1111, 1'b0), 64'h1);
        exp_cr = put_fld(exp_cr, 5, 4'b0000);
        chk(cr == exp_cr, "R3 clear form", 64'(cr), 64'(exp_cr));
        // R3: mode all zeros, mask 0110 -> 0110
        run(mk(6'd19, 5'd0, 1'b0, 4'b0110, 3'd5, 2'b01, 5'd0, 1'b0, 4'b0000, 1'b0), 64'h1);
        exp_cr = put_fld(exp_cr, 5, 4'b0110);
        chk(cr == exp_cr, "R3 set form", 64'(cr), 64'(exp_cr));
    endtask

    task automatic t_cr2cr;
        // R4: src 2 (1100), mode 1010 mask 1111 -> 1001 into field 7
        run(mk(6'd19, {3'd7, 2'b00}, 1'b0, 4'hF, 3'd2, 2'b10, 5'd0, 1'b0, 4'b1010, 1'b0), 64'd0);
        exp_cr = put_fld(exp_cr, 7, 4'b1001);
        chk(cr == exp_cr, "R4 full mask", 64'(cr), 64'(exp_cr));
        run(mk(6'd19, {3'd7, 2'b11}, 1'b0, 4'b0011, 3'd2, 2'b10, 5'd0, 1'b0, 4'b1010, 1'b0), 64'd0);
        exp_cr = put_fld(exp_cr, 7, 4'b0001);
        chk(cr == exp_cr, "R4 partial mask", 64'(cr), 64'(exp_cr));
    endtask

    task automatic t_bit;
        // R6: OR of n=1100 -> 1 into field 4 bit 1
        run(mk(6'd19, {2'd1, 3'd4}, 1'b1, 4'b1100, 3'd2, 2'b11, 5'd0, 1'b0, 4'b1111, 1'b0), 64'd0);
        exp_cr[31-16-1] = 1'b1;
        chk(cr == exp_cr, "R6 or set", 64'(cr), 64'(exp_cr));
        // R6: AND of n=1111 -> 1 into field 0 bit 3
        run(mk(6'd19, {2'd3, 3'd0}, 1'b0, 4'hF, 3'd2, 2'b11, 5'd0, 1'b0, 4'b1100, 1'b0), 64'd0);
        exp_cr[31-3] = 1'b1;
        chk(cr == exp_cr, "R6 and set", 64'(cr), 64'(exp_cr));
        // R6: AND of n=0011 -> 0 into field 4 bit 1
        run(mk(6'd19, {2'd1, 3'd4}, 1'b0, 4'hF, 3'd2, 2'b11, 5'd0, 1'b0, 4'b0000, 1'b0), 64'd0);
        exp_cr[31-16-1] = 1'b0;
        chk(cr == exp_cr, "R6 and clear", 64'(cr), 64'(exp_cr));
    endtask

    task automatic t_cr2int;
        // R7/R8: src 2 (1100) mode 1100 mask 1111 -> 15, Rc=1
        @(negedge clk);
        insn  = mk(6'd19, 5'd9, 1'b0, 4'hF, 3'd2, 2'b00, 5'd0, 1'b0, 4'b1100, 1'b1);
        opnd  = 64'd0;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        chk(int_we && int_rt == 5'd9, "R7 strobe and index", {58'd0, int_we, int_rt}, {58'd0, 1'b1, 5'd9});
        chk(int_res == 64'd15, "R7 value", int_res, 64'd15);
        exp_cr = put_fld(exp_cr, 0, 4'b0100);
        chk(cr == exp_cr, "R8 nonzero flags", 64'(cr), 64'(exp_cr));
        @(negedge clk);
        chk(!int_we, "R7 single pulse", 64'(int_we), 64'd0);
        // R8: zero result
        run(mk(6'd19, 5'd3, 1'b0, 4'h0, 3'd2, 2'b00, 5'd0, 1'b0, 4'b1100, 1'b1), 64'd0);
        exp_cr = put_fld(exp_cr, 0, 4'b0010);
        chk(int_res == 64'd0, "R7 zero value", int_res, 64'd0);
        chk(cr == exp_cr, "R8 zero flags", 64'(cr), 64'(exp_cr));
        // R8: Rc clear leaves CR alone; n = 0011 -> 3
        run(mk(6'd19, 5'd4, 1'b0, 4'hF, 3'd2, 2'b00, 5'd0, 1'b0, 4'b0000, 1'b0), 64'd0);
        chk(int_res == 64'd3, "R7 value low bits", int_res, 64'd3);
        chk(cr == exp_cr, "R8 no rc", 64'(cr), 64'(exp_cr));
    endtask

    task automatic t_illegal;
        // R2: wrong opcode, bit 26 set, wrong extended opcode
        run(mk(6'd31, 5'd0, 1'b0, 4'hF, 3'd1, 2'b01, 5'd0, 1'b0, 4'b0000, 1'b0), 64'd0);
        chk(illegal && !int_we, "R2 opcode", {62'd0, illegal, int_we}, 64'd2);
        chk(cr == exp_cr, "R2 opcode no write", 64'(cr), 64'(exp_cr));
        @(negedge clk);
        chk(!illegal, "R2 one cycle pulse", 64'(illegal), 64'd0);
        run(mk(6'd19, 5'd0, 1'b0, 4'hF, 3'd1, 2'b01, 5'd0, 1'b1, 4'b0000, 1'b0), 64'd0);
        chk(illegal && cr == exp_cr, "R2 bit26", 64'(cr), 64'(exp_cr));
        run(mk(6'd19, 5'd9, 1'b0, 4'hF, 3'd2, 2'b00, 5'd4, 1'b0, 4'b1100, 1'b1), 64'd0);
        chk(illegal && !int_we && cr == exp_cr, "R2 ext opcode", 64'(cr), 64'(exp_cr));
    endtask

    task automatic t_idle;
        // R10: a CR-writing word with valid low
        @(negedge clk);
        insn  = mk(6'd19, 5'd0, 1'b0, 4'hF, 3'd6, 2'b01, 5'd0, 1'b0, 4'b0000, 1'b0);
        valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(cr == exp_cr, "R10 cr held", 64'(cr), 64'(exp_cr));
        chk(!int_we && !illegal, "R10 strobes low", {62'd0, int_we, illegal}, 64'd0);
    endtask

    initial begin
        rst    = 1'b1;
        valid  = 1'b0;
        insn   = '0;
        opnd   = '0;
        exp_cr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_int2cr();
        t_setclr();
        t_cr2cr();
        t_bit();
        t_cr2int();
        t_illegal();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule